// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Serial Bus

This block is a target on a two-wire SMBus/I2C-style link. It holds a small file of byte-wide registers and shows every register to nearby logic on a flat parallel bus. The SCL and SDA inputs arrive already synchronised to the system clock. The block pulls SDA low through an open-drain enable. It detects START, repeated START and STOP from the SDA edges seen while SCL is high.

To write, the host addresses the target and sends a starting register index. It then sends a byte count, and after that the data bytes. The target stores the data bytes in consecutive registers, beginning at that index. To read, the host first sets the index with a short write. It then issues a repeated START with the read address. The target answers with the current byte count and then streams register bytes from the index onward, until the host returns a not-acknowledge.

Each transferred byte advances the index pointer. The pointer wraps within the file. One index past the file selects the byte-count register. Higher indices accept writes but store nothing.

Top module: `smb_idx_target`

## Requirements
- R1: The 7-bit target address is 0x6E, so the write address byte is 0xDC and the read address byte is 0xDD (R/W in bit 0, read = 1). Both are acknowledged. Any other address byte is not acknowledged. After a mismatched address the target acknowledges nothing until the next START.
- R2: A write runs START, 0xDC, index N, count X, then data bytes. The target acknowledges the index byte, the count byte and each of the first X data bytes. It stores those data bytes in registers N, N+1, and so on.
- R3: Data bytes beyond the first X of a write are not acknowledged and not stored. With X = 0, the first data byte is already not acknowledged.
- R4: The index pointer advances by one after every stored or sent byte. Only its low 4 bits change, so inside the 16-byte file the index wraps from 15 to 0.
- R5: Index 0x10 is the byte-count register, which resets to 16. A written data byte at index 0x10 replaces it. Writes at indices 0x11 to 0xFF are acknowledged and discarded. Reads at those indices return 0x00.
- R6: A read runs START, 0xDC, index N, repeated START, then 0xDD. The target first sends the byte-count register, then the registers starting at N. Bits go most significant first.
- R7: When the host does not acknowledge a byte the target sent, the target releases SDA. It keeps SDA released until the next STOP or START.
- R8: A START or STOP in the middle of a byte abandons the transfer. The partial byte is not stored. A following START begins a fresh frame.
- R9: The target only begins pulling SDA low while SCL is low.
- R10: After reset, all registers read 0x00, the count register holds 16 and SDA is released.
- R11: Register k appears on reg_bus bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| reg_bus | output | 128 | All 16 registers, register k at bits [8k+7:8k] |

## Verification
The hardest cases to reach are a START or STOP landing in the middle of a byte, and a frame that must be ignored after a wrong address. Neither occurs in well-formed host traffic. The bench therefore has a host task that clocks only part of a byte and then issues STOP, or a repeated START. The bench then confirms that the register bus is unchanged and that the next full frame works. For the ignore case, the bench sweeps every 7-bit address other than the target's. After each wrong address it sends a byte that would be a valid index, and checks that the target stays silent.

// File: rtl/smb_idx_target.sv
module smb_idx_target #(
  parameter logic [6:0] TGT_ADDR = 7'h6E,
  parameter int         NREG     = 16,
  parameter logic [7:0] CNT_RST  = 8'd16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] reg_bus
);
  localparam int         IW      = $clog2(NREG);
  localparam logic [7:0] CNT_IDX = 8'(NREG);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_IDX = 3'd2, S_CNT = 3'd3,
                         S_WR = 3'd4, S_RD = 3'd5, S_HOLD = 3'd6;

  logic       scl_q, sda_q;
  logic [2:0] st, nxt;
  logic [3:0] bitc;
  logic [7:0] sh, ptr, wcnt, cnt_reg;
  logic [7:0] regs [NREG];

  wire rise     = scl_i & ~scl_q;
  wire fall     = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire rx       = (st == S_ADDR) || (st == S_IDX) || (st == S_CNT) || (st == S_WR);
  wire in_file  = ptr < CNT_IDX;
  wire addr_hit = sh[7:1] == TGT_ADDR;

  wire [7:0] ptr_inc = {ptr[7:IW], ptr[IW-1:0] + IW'(1)};
  wire [7:0] rd_byte = in_file ? regs[ptr[IW-1:0]] : (ptr == CNT_IDX) ? cnt_reg : 8'h00;

  for (genvar k = 0; k < NREG; k++) begin : g_bus
    assign reg_bus[8*k +: 8] = regs[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      st      <= S_IDLE;
      nxt     <= S_IDLE;
      bitc    <= '0;
      sh      <= '0;
      ptr     <= '0;
      wcnt    <= '0;
      cnt_reg <= CNT_RST;
      sda_oe  <= 1'b0;
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_c) begin
        st     <= S_ADDR;
        bitc   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        bitc   <= '0;
        sda_oe <= 1'b0;
      end else if (rx) begin
        if (rise && bitc < 4'd8) begin
          sh   <= {sh[6:0], sda_i};
          bitc <= bitc + 4'd1;
        end else if (fall && bitc == 4'd8) begin
          bitc <= 4'd9;
          case (st)
            S_ADDR: begin
              sda_oe <= addr_hit;
              nxt    <= !addr_hit ? S_HOLD : (sh[0] ? S_RD : S_IDX);
            end
            S_IDX: begin
              sda_oe <= 1'b1;
              ptr    <= sh;
              nxt    <= S_CNT;
            end
            S_CNT: begin
              sda_oe <= 1'b1;
              wcnt   <= sh;
              nxt    <= S_WR;
            end
            default: begin
              if (wcnt != 8'd0) begin
                sda_oe <= 1'b1;
                wcnt   <= wcnt - 8'd1;
                ptr    <= ptr_inc;
                if (in_file) regs[ptr[IW-1:0]] <= sh;
                else if (ptr == CNT_IDX) cnt_reg <= sh;
                nxt    <= S_WR;
              end else begin
                sda_oe <= 1'b0;
                nxt    <= S_HOLD;
              end
            end
          endcase
        end else if (fall && bitc == 4'd9) begin
          bitc <= '0;
          st   <= nxt;
          if (nxt == S_RD) begin
            sh     <= cnt_reg;
            sda_oe <= ~cnt_reg[7];
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end else if (st == S_RD) begin
        if (rise && bitc < 4'd8) begin
          bitc <= bitc + 4'd1;
        end else if (rise && bitc == 4'd8) begin
          if (sda_i) st <= S_HOLD;
          else       bitc <= 4'd9;
        end else if (fall && bitc == 4'd8) begin
          sda_oe <= 1'b0;
        end else if (fall && bitc == 4'd9) begin
          sh     <= rd_byte;
          sda_oe <= ~rd_byte[7];
          ptr    <= ptr_inc;
          bitc   <= '0;
        end else if (fall && bitc != 4'd0) begin
          sh     <= {sh[6:0], 1'b0};
          sda_oe <= ~sh[6];
        end
      end
    end
  end
endmodule

// File: rtl/smb_idx_target_chk.sv
module smb_idx_target_chk #(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] reg_bus,
  input logic [2:0]        st
);
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_i));

  a_r7_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6) |-> !sda_oe);

  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe);

  a_r2_store_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(reg_bus) |-> !$past(scl_i));
endmodule

bind smb_idx_target smb_idx_target_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe(sda_oe), .reg_bus(reg_bus), .st(st)
);

// File: tb/sim_smb_idx_target.sv
module sim_smb_idx_target;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic sda_oe;
  logic [127:0] reg_bus;
  wire sda_line = host_sda & ~sda_oe;

  int checks = 0, fails = 0, r9_viol = 0;
  logic [7:0] m_regs [16];
  logic [7:0] m_cnt;

  always #10 clk = ~clk;

  smb_idx_target u0 (.clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
                     .sda_oe(sda_oe), .reg_bus(reg_bus));

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (sda_oe && !oe_prev && host_scl) r9_viol++;
    oe_prev <= sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (4) @(negedge clk); endtask

  task automatic bus_start();
    host_sda = 1'b1; q(); host_scl = 1'b1; q(); host_sda = 1'b0; q(); host_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    host_scl = 1'b0; host_sda = 1'b0; q(); host_scl = 1'b1; q(); host_sda = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      host_sda = b[i]; q(); host_scl = 1'b1; q(); q(); host_scl = 1'b0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    host_sda = 1'b1; q(); host_scl = 1'b1; q(); ack = ~sda_line; q(); host_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); host_scl = 1'b1; q(); b[i] = sda_line; q(); host_scl = 1'b0;
    end
    q(); host_sda = nack; q(); host_scl = 1'b1; q(); q(); host_scl = 1'b0; q(); host_sda = 1'b1;
  endtask

  function automatic logic [7:0] nxt_idx(input logic [7:0] p);
    return {p[7:4], p[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] p);
    return (p < 8'd16) ? m_regs[p[3:0]] : (p == 8'd16) ? m_cnt : 8'h00;
  endfunction

  task automatic check_bus(input string tag);
    logic [127:0] e;
    for (int k = 0; k < 16; k++) e[8*k +: 8] = m_regs[k];
    check(tag, reg_bus, e);
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [7:0] cnt, input int nb,
                          input logic [7:0] base);
    logic a;
    logic [7:0] p, d;
    bus_start();
    send_byte(8'hDC, a); check("R1 write address ack", a, 1);
    send_byte(idx, a);   check("R2 index ack", a, 1);
    send_byte(cnt, a);   check("R2 count ack", a, 1);
    p = idx;
    for (int j = 0; j < nb; j++) begin
      d = base + 8'(j * 37);
      send_byte(d, a);
      check(j < int'(cnt) ? "R2 data ack" : "R3 excess data nack", a, (j < int'(cnt)));
      if (j < int'(cnt)) begin
        if (p < 8'd16) m_regs[p[3:0]] = d;
        else if (p == 8'd16) m_cnt = d;
        p = nxt_idx(p);
      end
    end
    bus_stop();
    check_bus("R11 R4 R5 register bus after write");
  endtask

  task automatic do_read(input logic [7:0] idx, input int nb);
    logic a;
    logic [7:0] p, b;
    bus_start();
    send_byte(8'hDC, a); check("R1 write address ack", a, 1);
    send_byte(idx, a);   check("R6 index ack", a, 1);
    bus_start();
    send_byte(8'hDD, a); check("R1 R6 read address ack", a, 1);
    recv_byte(nb == 0, b); check("R6 R5 count byte first", b, m_cnt);
    p = idx;
    for (int j = 0; j < nb; j++) begin
      recv_byte(j == nb - 1, b);
      check("R6 R4 read data", b, m_read(p));
      p = nxt_idx(p);
    end
    q(); host_scl = 1'b1; q(); check("R7 released after nack", sda_line, 1);
    q(); host_scl = 1'b0; q(); check("R7 still released", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    logic a;
    for (int k = 0; k < 16; k++) m_regs[k] = 8'h00;
    m_cnt = 8'd16;
    repeat (5) @(negedge clk);
    check("R10 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    q();
    check("R10 sda released after reset", sda_oe, 0);
    check_bus("R10 R11 registers zero after reset");
    do_read(8'd0, 2);

    for (int n = 0; n < 16; n++) do_write(8'(n), 8'd3, 3, 8'(n * 11 + 3));
    for (int n = 0; n < 16; n++) do_read(8'(n), 4);

    do_write(8'd5, 8'd2, 4, 8'hA1);
    do_write(8'd9, 8'd0, 1, 8'h55);
    do_write(8'd14, 8'd4, 4, 8'hC3);
    do_read(8'd13, 6);

    do_write(8'h10, 8'd1, 1, 8'h05);
    do_read(8'd2, 3);
    do_write(8'h23, 8'd2, 2, 8'h77);
    do_read(8'h23, 2);
    do_read(8'h10, 2);

    for (int ad = 0; ad < 128; ad++) begin
      if (ad != 8'h6E) begin
        bus_start();
        send_byte({7'(ad), 1'b0}, a); check("R1 foreign address nack", a, 0);
        send_byte(8'h00, a);          check("R1 ignored until START", a, 0);
        bus_stop();
      end
    end
    check_bus("R1 registers untouched by foreign frames");

    bus_start();
    send_byte(8'hDC, a); send_byte(8'd3, a); send_byte(8'd2, a);
    send_bits(8'hFF, 4);
    bus_stop();
    check_bus("R8 stop mid-byte stores nothing");
    bus_start();
    send_byte(8'hDC, a); send_byte(8'd4, a); send_byte(8'd1, a);
    send_bits(8'h3C, 5);
    bus_start();
    send_byte(8'hDC, a); check("R8 fresh frame after restart", a, 1);
    bus_stop();
    check_bus("R8 restart mid-byte stores nothing");
    do_write(8'd7, 8'd2, 2, 8'h9E);
    do_read(8'd6, 3);

    check("R9 sda driven only with scl low", r9_viol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule